// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the first four dwords of a type-0 PCI configuration header. A configuration agent presents a byte offset together with a read strobe, a write strobe, or both, and 32-bit write data. The identity fields are fixed by parameters: vendor ID, device ID, the combined class code and revision word, and the header type byte. The block keeps three fields that software can write: command, latency timer and cache line size.

Read data is registered. It appears on the clock after the read strobe, together with a valid flag. The status and BIST fields cannot be written. Status and BIST always read as zero. Any offset other than the four header dwords reads as zero and ignores writes. Byte enables are not modelled. Every write carries a full dword.

Top module: `pci_cfg_hdr`

## Requirements
- R1: After reset the command, latency timer and cache line size fields are zero, and cfg_rvalid is low until the first read strobe.
- R2: A read of offset 0x00 returns DEVICE_ID in bits 31:16 and VENDOR_ID in bits 15:0.
- R3: A write to offset 0x04 stores cfg_wdata[15:0] as the command field, and cfg_wdata[31:16] is discarded. A read of 0x04 returns the command field in bits 15:0 and zero in bits 31:16 (status).
- R4: A read of offset 0x08 returns the CLASS_REV parameter unchanged.
- R5: A write to offset 0x0C stores cfg_wdata[15:8] as the latency timer and cfg_wdata[7:0] as the cache line size. A read of 0x0C returns HDR_TYPE in bits 23:16, the latency timer in bits 15:8 and the cache line size in bits 7:0.
- R6: Bits 31:24 of offset 0x0C (BIST) read as zero whatever was written there.
- R7: A read of any offset other than 0x00, 0x04, 0x08 or 0x0C returns zero. A write to such an offset leaves the command, latency timer and cache line size fields unchanged.
- R8: cfg_rvalid is high exactly in the cycle after a cycle with cfg_rd high. In that cycle cfg_rdata holds the value for the offset sampled with the strobe.
- R9: When a read and a write to the same offset fall in one cycle, the read returns the contents from before the write. The written value is seen by the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_offs | input | OFFS_W | Configuration byte offset |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one clock after cfg_rd |

## Verification
A read and a write can land in the same cycle, either on the same header dword or on different ones. The random stimulus raises both strobes together on many operations. Directed cases aim a combined read and write at the command dword and at the timer dword. The bench model works out the read result from the field values held before the write is applied. It then updates the fields, so a read returning the new data is reported as a failure. The next read of the same dword confirms that the write took effect.

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr #(
  parameter int          OFFS_W    = 8,
  parameter logic [15:0] VENDOR_ID = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID = 16'h3C4D,
  parameter logic [31:0] CLASS_REV = 32'h0C033005,
  parameter logic [7:0]  HDR_TYPE  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFFS_W-1:0] cfg_offs,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_rd,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_rvalid
);

  localparam logic [OFFS_W-1:0] OFF_ID   = OFFS_W'(8'h00);
  localparam logic [OFFS_W-1:0] OFF_CMD  = OFFS_W'(8'h04);
  localparam logic [OFFS_W-1:0] OFF_CLS  = OFFS_W'(8'h08);
  localparam logic [OFFS_W-1:0] OFF_MISC = OFFS_W'(8'h0C);

  logic [15:0] cmd_q;
  logic [7:0]  lat_q;
  logic [7:0]  cls_q;
  logic [31:0] rd_mux;

  logic hit_cmd, hit_misc;
  assign hit_cmd  = cfg_offs == OFF_CMD;
  assign hit_misc = cfg_offs == OFF_MISC;

  logic unused_wbits;
  assign unused_wbits = ^cfg_wdata[31:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      lat_q <= '0;
      cls_q <= '0;
    end else if (cfg_wr) begin
      if (hit_cmd)  cmd_q <= cfg_wdata[15:0];
      if (hit_misc) begin
        lat_q <= cfg_wdata[15:8];
        cls_q <= cfg_wdata[7:0];
      end
    end
  end

  always_comb begin
    case (cfg_offs)
      OFF_ID:   rd_mux = {DEVICE_ID, VENDOR_ID};
      OFF_CMD:  rd_mux = {16'h0000, cmd_q};
      OFF_CLS:  rd_mux = CLASS_REV;
      OFF_MISC: rd_mux = {8'h00, HDR_TYPE, lat_q, cls_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) cfg_rdata <= rd_mux;
    end
  end

  // R3: command changes only through a write to its dword
  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_offs == OFF_CMD) |=> $stable(cmd_q));

  // R3: a write to the command dword lands in the low half
  p_cmd_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_offs == OFF_CMD) |=> cmd_q == $past(cfg_wdata[15:0]));

  // R5: timer fields change only through a write to their dword
  p_misc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_offs == OFF_MISC) |=> ($stable(lat_q) && $stable(cls_q)));

  // R6: BIST byte of returned data is zero
  p_bist_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && $past(cfg_offs) == OFF_MISC) |-> cfg_rdata[31:24] == 8'h00);

  // R3: status half of returned data is zero
  p_status_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && $past(cfg_offs) == OFF_CMD) |-> cfg_rdata[31:16] == 16'h0000);

  // R7: offsets outside the header return zero
  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && $past(cfg_offs) != OFF_ID && $past(cfg_offs) != OFF_CMD &&
     $past(cfg_offs) != OFF_CLS && $past(cfg_offs) != OFF_MISC) |-> cfg_rdata == 32'h0);

  // R8: read data is unchanged when no read was issued
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata));

endmodule

// File: tb/tb_pci_cfg_hdr.sv
module tb_pci_cfg_hdr;
  localparam logic [15:0] VID = 16'h1A2B;
  localparam logic [15:0] DID = 16'h3C4D;
  localparam logic [31:0] CRV = 32'h0C033005;
  localparam logic [7:0]  HDT = 8'h00;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] cfg_offs = 0;
  logic cfg_wr = 0, cfg_rd = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic cfg_rvalid;

  pci_cfg_hdr #(.OFFS_W(8), .VENDOR_ID(VID), .DEVICE_ID(DID),
                .CLASS_REV(CRV), .HDR_TYPE(HDT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_offs(cfg_offs), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  logic [15:0] m_cmd = 0;
  logic [7:0]  m_lat = 0, m_cls = 0;

  function automatic logic [31:0] exp_read(logic [7:0] o);
    case (o)
      8'h00: return {DID, VID};
      8'h04: return {16'h0, m_cmd};
      8'h08: return CRV;
      8'h0C: return {8'h00, HDT, m_lat, m_cls};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic rd, logic wr, logic [7:0] o, logic [31:0] d, string req);
    logic [31:0] e;
    @(negedge clk);
    cfg_rd = rd; cfg_wr = wr; cfg_offs = o; cfg_wdata = d;
    e = exp_read(o);
    if (wr) begin
      if (o == 8'h04) m_cmd = d[15:0];
      if (o == 8'h0C) begin m_lat = d[15:8]; m_cls = d[7:0]; end
    end
    @(negedge clk);
    cfg_rd = 0; cfg_wr = 0;
    check({req, " R8 valid"}, {31'h0, cfg_rvalid}, {31'h0, rd});
    if (rd) check(req, cfg_rdata, e);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] o;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rvalid after reset", {31'h0, cfg_rvalid}, 32'h0);
    op(1, 0, 8'h04, 0, "R1 cmd reset");
    op(1, 0, 8'h0C, 0, "R1 misc reset");
    op(1, 0, 8'h00, 0, "R2 ids");
    op(1, 0, 8'h08, 0, "R4 class rev");
    op(0, 1, 8'h04, 32'hFFFF_A5C3, "R3 write");
    op(1, 0, 8'h04, 0, "R3 status ignored");
    op(0, 1, 8'h0C, 32'hFF7E_5A81, "R5 write");
    op(1, 0, 8'h0C, 0, "R6 bist zero R5 fields");
    op(0, 1, 8'h10, 32'hFFFF_FFFF, "R7 write unimpl");
    op(0, 1, 8'h05, 32'h0000_0000, "R7 write unaligned");
    op(1, 0, 8'h04, 0, "R7 cmd untouched");
    op(1, 0, 8'h0C, 0, "R7 misc untouched");
    op(1, 0, 8'h40, 0, "R7 read unimpl");
    op(1, 0, 8'hFC, 0, "R7 read top");
    op(1, 1, 8'h04, 32'h0000_1234, "R9 cmd same cycle");
    op(1, 0, 8'h04, 0, "R9 cmd after");
    op(1, 1, 8'h0C, 32'h0000_9988, "R9 misc same cycle");
    op(1, 0, 8'h0C, 0, "R9 misc after");
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 6)
        0: o = 8'h00;
        1: o = 8'h04;
        2: o = 8'h08;
        3: o = 8'h0C;
        default: o = 8'($urandom);
      endcase
      op(1'($urandom), 1'($urandom), o, $urandom, "R8 random");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule